// File: doc/BRIEF.md
# Enveloped Priority Push Tenure Selector

This block sits in the bus interface of a copy-back cache controller. It handles one case: the controller has finished the address tenure of a line read, and the data for that read has not arrived yet. During that window another master may snoop a line that this cache holds modified. The block checks each such snoop against the pending read. If the snoop collides with the read, the snooping master is told to retry. Otherwise a high-priority push of the modified line is queued, and its address tenure is requested.

Once the push address has been accepted, two operations wait for the data bus: the older load and the newer pipelined store. By default a qualified data bus grant serves the load. If the write-only qualifier arrives together with the grant, that data tenure serves the store instead. The push can then finish inside the read's address and data tenures, and two buses that depend on each other cannot deadlock. The block reports which operation owns each data tenure for its full length. Beat data and the data path are outside this block.

Top module: `push_tenure_sel`

## Requirements
- R1: After reset, `artry_out`, `push_req`, `rd_pending`, `dten_busy` and `dten_store` are all 0.
- R2: A `rd_issue` pulse while no read is pending sets `rd_pending` from the next cycle. `rd_pending` stays 1 until the edge that ends the load's data tenure. A `rd_issue` while a read is pending is ignored.
- R3: A `snp_hitm` whose line address (bits ADDR_W-1 down to LINE_OFS) equals the pending read's line address raises `artry_out` in the following cycle, every time it occurs, until the load's data tenure has ended. No push is queued for it.
- R4: A `snp_hitm` that does not collide with the pending read and finds the push slot empty leaves `artry_out` at 0. From the next cycle, `push_req` is 1 and `push_addr` equals the snooped address. Both hold until `push_aack` is seen.
- R5: A `snp_hitm` that arrives while a push is queued (address requested, or address accepted and waiting for data) raises `artry_out` in the following cycle and leaves `push_addr` unchanged.
- R6: A qualified `bus_grant` with `wr_only` at 0 and a read pending starts a load tenure. `dten_busy` is 1 and `dten_store` is 0 from the next cycle.
- R7: A qualified `bus_grant` with `wr_only` at 1, while a read is pending and a push write is queued behind it, starts a store tenure (`dten_store` is 1). This gives the order load address, push address, push data, load data.
- R8: `wr_only` has no effect when no push write is queued. The grant then starts a load tenure.
- R9: When a store tenure has ended with the read still pending, the next grant without the qualifier starts the load tenure, and `rd_pending` clears when that tenure ends.
- R10: A data tenure keeps `dten_busy` at 1 for exactly BEATS cycles (default 4), with `dten_store` stable throughout. Grants that arrive during a tenure are ignored.
- R11: A grant with a push write queued and no read pending starts a store tenure. A grant with nothing queued starts no tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_issue | input | 1 | Read address tenure completed this cycle |
| rd_addr | input | ADDR_W | Address of the read being issued |
| snp_hitm | input | 1 | Snoop from another master hit a modified line |
| snp_addr | input | ADDR_W | Snooped address |
| push_aack | input | 1 | Push address tenure accepted |
| bus_grant | input | 1 | Qualified data bus grant |
| wr_only | input | 1 | Write-only qualifier sampled with the grant |
| artry_out | output | 1 | Address retry to the snooping master |
| push_req | output | 1 | Address bus request for the push write |
| push_addr | output | ADDR_W | Address of the queued push |
| rd_pending | output | 1 | Read address done, its data not yet received |
| dten_busy | output | 1 | A data tenure is in progress |
| dten_store | output | 1 | Owner of the current tenure: 1 store, 0 load |

## Verification
The assertions assume that `push_aack` is asserted only while `push_req` is high and that `rd_issue` occurs only when no read is pending. They also assume that `bus_grant` is not held into the cycle after a tenure ends. The bench drives the interface only through tasks that respect these rules: it acknowledges a push only when its model says the address is requested, and it drops the grant before the last beat. The random phase draws half of its snoop addresses from the pending read's line, so collisions, accepted pushes and pushes refused because the slot is full all occur many times.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_ADDR = 2'd1,
      SLOT_DATA = 2'd2
   } slot_t;
endpackage

// File: rtl/coh_track.sv
module coh_track
   import tenure_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issue,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              snp_hitm,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              push_aack,
   input  logic              ld_done,
   input  logic              st_done,
   output logic              rd_pending,
   output logic              artry_out,
   output logic              push_req,
   output logic [ADDR_W-1:0] push_addr,
   output logic              wr_queued
);
   localparam int TAG_W = ADDR_W - LINE_OFS;

   logic [ADDR_W-1:0] rd_addr_q;
   logic [ADDR_W-1:0] push_addr_q;
   logic              rd_pend_q;
   logic              artry_q;
   logic              line_eq;
   slot_t             slot_q;

   generate
      if (LINE_OFS == 0) begin : g_full_cmp
         assign line_eq = (snp_addr == rd_addr_q);
      end else begin : g_line_cmp
         logic [TAG_W-1:0] snp_tag, rd_tag;
         assign snp_tag = snp_addr[ADDR_W-1:LINE_OFS];
         assign rd_tag  = rd_addr_q[ADDR_W-1:LINE_OFS];
         assign line_eq = (snp_tag == rd_tag);
      end
   endgenerate

   logic collide, slot_full, accept;
   assign collide   = snp_hitm && rd_pend_q && line_eq;
   assign slot_full = snp_hitm && !collide && (slot_q != SLOT_FREE);
   assign accept    = snp_hitm && !collide && (slot_q == SLOT_FREE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend_q   <= 1'b0;
         rd_addr_q   <= '0;
         artry_q     <= 1'b0;
         slot_q      <= SLOT_FREE;
         push_addr_q <= '0;
      end else begin
         artry_q <= collide || slot_full;
         if (ld_done) begin
            rd_pend_q <= 1'b0;
         end else if (rd_issue && !rd_pend_q) begin
            rd_pend_q <= 1'b1;
            rd_addr_q <= rd_addr;
         end
         unique case (slot_q)
            SLOT_FREE: if (accept) begin
               slot_q      <= SLOT_ADDR;
               push_addr_q <= snp_addr;
            end
            SLOT_ADDR: if (push_aack) slot_q <= SLOT_DATA;
            SLOT_DATA: if (st_done)   slot_q <= SLOT_FREE;
            default:   slot_q <= SLOT_FREE;
         endcase
      end
   end

   assign rd_pending = rd_pend_q;
   assign artry_out  = artry_q;
   assign push_req   = (slot_q == SLOT_ADDR);
   assign push_addr  = push_addr_q;
   assign wr_queued  = (slot_q == SLOT_DATA);
endmodule

// File: rtl/dten_arb.sv
module dten_arb #(
   parameter int BEATS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_grant,
   input  logic wr_only,
   input  logic rd_pending,
   input  logic wr_queued,
   output logic dten_busy,
   output logic dten_store,
   output logic ld_done,
   output logic st_done
);
   localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   initial begin
      if (BEATS < 1) $fatal(1, "dten_arb: BEATS must be at least 1");
   end

   logic busy_q, store_q, last;
   logic take, pick_store;

   assign take       = bus_grant && !busy_q && (rd_pending || wr_queued);
   assign pick_store = wr_queued && (wr_only || !rd_pending);

   generate
      if (BEATS == 1) begin : g_single
         assign last = busy_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt_q <= '0;
            else if (take) cnt_q <= '0;
            else if (busy_q) cnt_q <= cnt_q + 1'b1;
         end
         assign last = busy_q && (cnt_q == CNT_W'(BEATS - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         store_q <= 1'b0;
      end else if (take) begin
         busy_q  <= 1'b1;
         store_q <= pick_store;
      end else if (last) begin
         busy_q  <= 1'b0;
         store_q <= 1'b0;
      end
   end

   assign dten_busy  = busy_q;
   assign dten_store = store_q;
   assign ld_done    = last && !store_q;
   assign st_done    = last && store_q;
endmodule

// File: rtl/push_tenure_sel.sv
module push_tenure_sel #(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 5,
   parameter int BEATS    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issue,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              snp_hitm,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              push_aack,
   input  logic              bus_grant,
   input  logic              wr_only,
   output logic              artry_out,
   output logic              push_req,
   output logic [ADDR_W-1:0] push_addr,
   output logic              rd_pending,
   output logic              dten_busy,
   output logic              dten_store
);
   initial begin
      if (LINE_OFS < 0 || LINE_OFS >= ADDR_W)
         $fatal(1, "push_tenure_sel: LINE_OFS out of range");
   end

   logic wr_queued, ld_done, st_done;

   coh_track #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_issue   (rd_issue),
      .rd_addr    (rd_addr),
      .snp_hitm   (snp_hitm),
      .snp_addr   (snp_addr),
      .push_aack  (push_aack),
      .ld_done    (ld_done),
      .st_done    (st_done),
      .rd_pending (rd_pending),
      .artry_out  (artry_out),
      .push_req   (push_req),
      .push_addr  (push_addr),
      .wr_queued  (wr_queued)
   );

   dten_arb #(.BEATS(BEATS)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_grant  (bus_grant),
      .wr_only    (wr_only),
      .rd_pending (rd_pending),
      .wr_queued  (wr_queued),
      .dten_busy  (dten_busy),
      .dten_store (dten_store),
      .ld_done    (ld_done),
      .st_done    (st_done)
   );
endmodule

// File: rtl/push_tenure_sel_chk.sv
module push_tenure_sel_chk #(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 5,
   parameter int BEATS    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snp_hitm,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              rd_issue,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              push_aack,
   input logic              bus_grant,
   input logic              wr_only,
   input logic              artry_out,
   input logic              push_req,
   input logic [ADDR_W-1:0] push_addr,
   input logic              rd_pending,
   input logic              dten_busy,
   input logic              dten_store,
   input logic              wr_queued
);
   localparam int RUN_W = $clog2(BEATS + 1) + 1;

   logic [ADDR_W-1:0] line_q;
   logic [RUN_W-1:0]  run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         run_q  <= '0;
      end else begin
         if (rd_issue && !rd_pending) line_q <= rd_addr >> LINE_OFS;
         run_q <= dten_busy ? run_q + 1'b1 : '0;
      end
   end

   // R2
   read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pending && !dten_busy |=> rd_pending);

   // R3
   collide_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hitm && rd_pending && ((snp_addr >> LINE_OFS) == line_q) |=> artry_out);

   // R4
   push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !push_aack |=> push_req && $stable(push_addr));

   // R5
   slot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hitm && (push_req || wr_queued) |=> artry_out && $stable(push_addr));

   // R6
   load_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant && !dten_busy && rd_pending && !wr_only |=> dten_busy && !dten_store);

   // R7
   store_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant && !dten_busy && rd_pending && wr_queued && wr_only |=> dten_busy && dten_store);

   // R10
   owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dten_busy && $past(dten_busy) |-> $stable(dten_store));

   // R10
   tenure_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dten_busy && (run_q == RUN_W'(BEATS - 1)) |=> !dten_busy);
endmodule

bind push_tenure_sel push_tenure_sel_chk #(
   .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .BEATS(BEATS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .snp_hitm(snp_hitm), .snp_addr(snp_addr),
   .rd_issue(rd_issue), .rd_addr(rd_addr), .push_aack(push_aack),
   .bus_grant(bus_grant), .wr_only(wr_only), .artry_out(artry_out),
   .push_req(push_req), .push_addr(push_addr), .rd_pending(rd_pending),
   .dten_busy(dten_busy), .dten_store(dten_store), .wr_queued(wr_queued)
);

// File: tb/test_push_tenure_sel.sv
`timescale 1ns/1ps
module test_push_tenure_sel;
   localparam int AW = 32;
   localparam int LO = 5;
   localparam int NB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_issue = 1'b0, snp_hitm = 1'b0, push_aack = 1'b0;
   logic bus_grant = 1'b0, wr_only = 1'b0;
   logic [AW-1:0] rd_addr = '0, snp_addr = '0;
   logic artry_out, push_req, rd_pending, dten_busy, dten_store;
   logic [AW-1:0] push_addr;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   // model state
   bit m_rd = 0;
   logic [AW-1:0] m_rdaddr = '0;
   int m_slot = 0;
   logic [AW-1:0] m_paddr = '0;

   always #4 clk = ~clk;

   push_tenure_sel #(.ADDR_W(AW), .LINE_OFS(LO), .BEATS(NB)) i_push_tenure_sel (
      .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .rd_addr(rd_addr),
      .snp_hitm(snp_hitm), .snp_addr(snp_addr), .push_aack(push_aack),
      .bus_grant(bus_grant), .wr_only(wr_only), .artry_out(artry_out),
      .push_req(push_req), .push_addr(push_addr), .rd_pending(rd_pending),
      .dten_busy(dten_busy), .dten_store(dten_store)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   function automatic bit same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
      return (a >> LO) == (b >> LO);
   endfunction

   function automatic bit exp_retry(input logic [AW-1:0] a);
      return (m_rd && same_line(a, m_rdaddr)) || (m_slot != 0);
   endfunction

   function automatic bit exp_store(input bit q);
      return (m_slot == 2) && (q || !m_rd);
   endfunction

   task automatic do_read(input logic [AW-1:0] a);
      rd_issue = 1'b1; rd_addr = a;
      tick();
      rd_issue = 1'b0;
      if (!m_rd) begin m_rd = 1; m_rdaddr = a; end
      chk("R2", rd_pending, 1);
   endtask

   task automatic do_snoop(input logic [AW-1:0] a);
      bit r;
      r = exp_retry(a);
      snp_hitm = 1'b1; snp_addr = a;
      tick();
      snp_hitm = 1'b0;
      if (!r) begin m_slot = 1; m_paddr = a; end
      chk(r ? ((m_rd && same_line(a, m_rdaddr)) ? "R3" : "R5") : "R4", artry_out, r);
      chk("R4", push_req, m_slot == 1);
      if (m_slot != 0) chk("R5", push_addr, m_paddr);
   endtask

   task automatic do_aack();
      push_aack = 1'b1;
      tick();
      push_aack = 1'b0;
      m_slot = 2;
      chk("R4", push_req, 0);
   endtask

   task automatic do_grant(input bit q);
      bit go, st;
      go = m_rd || (m_slot == 2);
      st = exp_store(q);
      bus_grant = 1'b1; wr_only = q;
      tick();
      bus_grant = 1'b0; wr_only = 1'b0;
      chk("R11", dten_busy, go);
      if (go) begin
         chk(st ? "R7" : "R6", dten_store, st);
         for (int b = 1; b < NB; b++) begin
            if (b == 1) begin bus_grant = 1'b1; wr_only = ~q; end
            tick();
            bus_grant = 1'b0; wr_only = 1'b0;
            chk("R10", dten_busy, 1);
            chk("R10", dten_store, st);
         end
         tick();
         chk("R10", dten_busy, 0);
         if (st) m_slot = 0; else m_rd = 0;
         chk("R9", rd_pending, m_rd);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog expired: actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", {artry_out, push_req, rd_pending, dten_busy, dten_store}, 0);

      // directed: load-addr, push-addr, push-data, load-data
      do_read(32'h0000_1000);
      do_read(32'h0000_5000);            // R2 ignored while pending
      do_snoop(32'h0000_1004);           // R3 collision
      do_snoop(32'h0000_101C);           // R3 again
      do_snoop(32'h0000_2040);           // R4 accepted
      do_snoop(32'h0000_3000);           // R5 slot requesting
      do_aack();
      do_snoop(32'h0000_4000);           // R5 slot waiting data
      do_grant(1'b1);                    // R7 store steals tenure
      chk("R7", rd_pending, 1);
      do_snoop(32'h0000_1008);           // R3 until load data ends
      do_grant(1'b0);                    // R9 load tenure
      chk("R9", rd_pending, 0);
      do_snoop(32'h0000_1000);           // R3 window closed -> R4 push
      do_aack();
      do_grant(1'b0);                    // R11 store, no read pending

      // R8 qualifier without queued write
      do_read(32'h0000_8000);
      do_grant(1'b1);
      chk("R8", rd_pending, 0);
      // R11 grant with nothing queued
      do_grant(1'b0);

      // random phase
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [AW-1:0] a;
         op = int'($urandom % 4);
         case (op)
            0: if (!m_rd) do_read({20'h0, 12'($urandom)});
            1: begin
               if (m_rd && ($urandom % 2 == 1))
                  a = {m_rdaddr[AW-1:LO], LO'($urandom)};
               else
                  a = {20'h0, 12'($urandom)};
               do_snoop(a);
            end
            2: if (m_slot == 1) do_aack();
            default: do_grant(1'($urandom));
         endcase
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule